// File: doc/BRIEF.md
# Stereo Colour-Transition Matcher

This block pairs colour transitions seen by a left and a right camera on the same image row, to measure how far each feature has shifted between the two views. Each transition record carries a row number, an x position and a pair of colour codes (the colour before the edge and the colour after it). Left and right records arrive on two independent valid/ready streams and are buffered in their own input queues. Matched pairs leave through a third queue as a valid/ready result stream. Each result carries the row, the disparity (left x minus right x) and the mean of the two x positions.

A small associative store holds up to `CAM_ENTRIES` left transitions of one row. The head of the right queue is compared against every stored entry in a single cycle. The first entry in store order that has the same colour pair and an acceptable disparity wins. That entry and every entry before it are then removed, and the store is topped up with further left records of the same row. When no full pair exists, a partial match is tried: one stored entry must share the right record's starting colour and a later stored entry its ending colour. Both entries then produce a result, in that order, which stands for one extra edge that only the left view resolved. When the right stream moves to a new row, the store is emptied and refilled for that row.

The controller has four states. `ST_IDLE` waits for a right record. It moves to `ST_LOAD` when the store must be emptied for a new row, or when more same-row left records can be added; otherwise it moves to `ST_MATCH`. `ST_LOAD` takes one left record per cycle: stale rows are dropped, same-row records are stored, and it moves to `ST_MATCH` when neither applies. `ST_MATCH` does one of three things: it emits a full match and returns to `ST_IDLE`, it emits the first half of a partial match and moves to `ST_SECOND`, or it drops the right record and returns to `ST_IDLE`. It stays in place while the result queue is full. `ST_SECOND` emits the second half of a partial match and returns to `ST_IDLE`.

Top module: `stereo_matcher`

## Requirements
- R1: After reset, `l_ready` and `r_ready` are 1 and `m_valid` is 0.
- R2: A right record whose from and to colours both equal those of a stored left entry, with 0 <= left x − right x <= `MAX_DISP`, yields one result. The result carries the right record's row, disparity = left x − right x, and x mean = floor((left x + right x) / 2).
- R3: Entries with the right colours but a disparity above `MAX_DISP`, or a negative one, are skipped. The lowest-positioned entry that passes is chosen, and a disparity of exactly `MAX_DISP` is accepted.
- R4: After a full match on the entry at store position k, positions 0..k are removed. Later right records of that row can only pair with entries that were stored after it.
- R5: The store holds at most `CAM_ENTRIES` left records per load (default 8). A left record beyond that is unreachable until matches free room, after which same-row left records are added in arrival order.
- R6: With no full match, when one entry at position i has the right record's from colour and another at position j > i has its to colour, both within the disparity window, two results are emitted: entry i first, then entry j. Positions 0..j are then removed.
- R7: A right record with neither a full nor a partial match is consumed without a result and leaves the stored entries unchanged.
- R8: A right record whose row differs from the stored row empties the store, which is then reloaded for the new row. Left records with a lower row are dropped. A right record with no same-row left data is consumed without a result.
- R9: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and all result fields stay unchanged.
- R10: When the result queue is full, matching pauses, and no record on any stream is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_valid | input | 1 | Left record offered |
| l_ready | output | 1 | Left queue has room |
| l_row | input | 9 | Left record row |
| l_x | input | 10 | Left record x position |
| l_from | input | 4 | Left colour before the edge |
| l_to | input | 4 | Left colour after the edge |
| r_valid | input | 1 | Right record offered |
| r_ready | output | 1 | Right queue has room |
| r_row | input | 9 | Right record row |
| r_x | input | 10 | Right record x position |
| r_from | input | 4 | Right colour before the edge |
| r_to | input | 4 | Right colour after the edge |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Consumer accepts result |
| m_row | output | 9 | Result row |
| m_disp | output | 10 | Result disparity |
| m_xmean | output | 10 | Result mean x position |

## Verification
The bench builds the block with `CAM_ENTRIES` = 8, `FIFO_DEPTH` = 16 and `MAX_DISP` = 150. The 16-deep input queues let one row's ten left records wait complete before any right record arrives. This makes the store's eight-entry limit and the later top-up visible, so a ninth left record can be shown unreachable until matches free room. The 150 window puts the accept-at-limit, over-limit and negative-disparity cases on distinct x values. Holding `m_ready` low across twenty rows fills the 16-deep result queue, which forces `ST_MATCH` to pause and shows that every held-back pair still drains in order.

// File: rtl/stm_pkg.sv
package stm_pkg;
    localparam int ROW_W = 9;
    localparam int X_W   = 10;
    localparam int COL_W = 4;

    typedef struct packed {
        logic [X_W-1:0]   x;
        logic [COL_W-1:0] c_from;
        logic [COL_W-1:0] c_to;
    } cam_ent_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        cam_ent_t         body;
    } trans_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [X_W-1:0]   disp;
        logic [X_W-1:0]   xmean;
    } pair_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_MATCH  = 2'd2,
        ST_SECOND = 2'd3
    } mstate_t;
endpackage

// File: rtl/stm_fifo.sv
module stm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CAP);
    assign data_o  = mem[rd_q];

    always_ff @(posedge clk_i) begin
        if (push_i) mem[wr_q] <= data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + PTR_W'(1);
            if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + PTR_W'(1);
            if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
            else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assert_fifo_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> (cnt_q != CAP));
    assert_fifo_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/stm_cam.sv
module stm_cam
    import stm_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int MAX_DISP = 150,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          flush_i,
    input  logic                          load_i,
    input  cam_ent_t                      load_data_i,
    input  logic                          shift_i,
    input  logic [CNT_W-1:0]              shift_n_i,
    input  logic [COL_W-1:0]              probe_from_i,
    input  logic [COL_W-1:0]              probe_to_i,
    input  logic [X_W-1:0]                probe_x_i,
    output logic [CNT_W-1:0]              count_o,
    output logic [ENTRIES-1:0][X_W-1:0]   x_o,
    output logic [ENTRIES-1:0]            full_hit_o,
    output logic [ENTRIES-1:0]            from_hit_o,
    output logic [ENTRIES-1:0]            to_hit_o
);
    localparam logic [X_W-1:0]   DMAX = X_W'(MAX_DISP);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(ENTRIES);

    cam_ent_t         ent_q  [ENTRIES];
    cam_ent_t         ent_sh [ENTRIES];
    logic [CNT_W-1:0] cnt_q;

    assign count_o = cnt_q;

    // Entries move down by shift_n positions; the vacated tail is don't-care.
    always_comb begin
        logic [CNT_W:0] src;
        for (int i = 0; i < ENTRIES; i++) begin
            src       = (CNT_W+1)'(i) + {1'b0, shift_n_i};
            ent_sh[i] = ent_q[i];
            if (src < (CNT_W+1)'(ENTRIES)) ent_sh[i] = ent_q[src[IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (shift_i)                             ent_q[i] <= ent_sh[i];
            else if (load_i && cnt_q == CNT_W'(i))   ent_q[i] <= load_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (flush_i) cnt_q <= '0;
        else if (shift_i) cnt_q <= cnt_q - shift_n_i;
        else if (load_i)  cnt_q <= cnt_q + CNT_W'(1);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [X_W:0] diff;
        logic         in_rng, live;
        assign diff   = {1'b0, ent_q[g].x} - {1'b0, probe_x_i};
        assign in_rng = !diff[X_W] && (diff[X_W-1:0] <= DMAX);
        assign live   = (cnt_q > CNT_W'(g));
        assign x_o[g]        = ent_q[g].x;
        assign from_hit_o[g] = live && in_rng && (ent_q[g].c_from == probe_from_i);
        assign to_hit_o[g]   = live && in_rng && (ent_q[g].c_to == probe_to_i);
        assign full_hit_o[g] = from_hit_o[g] && (ent_q[g].c_to == probe_to_i);
    end

    assert_cam_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CAP);
    assert_cam_load_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> (cnt_q < CAP));
    assert_cam_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |-> (shift_n_i != '0 && shift_n_i <= cnt_q));
endmodule

// File: rtl/stm_ctrl.sv
module stm_ctrl
    import stm_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int MAX_DISP = 150,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        lq_empty_i,
    input  logic [ROW_W-1:0]            lq_row_i,
    output logic                        lq_pop_o,
    input  logic                        rq_empty_i,
    input  logic [ROW_W-1:0]            rq_row_i,
    input  logic [X_W-1:0]              rq_x_i,
    output logic                        rq_pop_o,
    input  logic [CNT_W-1:0]            cam_count_i,
    input  logic [ENTRIES-1:0][X_W-1:0] cam_x_i,
    input  logic [ENTRIES-1:0]          full_hit_i,
    input  logic [ENTRIES-1:0]          from_hit_i,
    input  logic [ENTRIES-1:0]          to_hit_i,
    output logic                        cam_flush_o,
    output logic                        cam_load_o,
    output logic                        cam_shift_o,
    output logic [CNT_W-1:0]            cam_shift_n_o,
    input  logic                        res_full_i,
    output logic                        res_push_o,
    output pair_t                       res_data_o
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(ENTRIES);

    mstate_t          state_q, state_d;
    logic [ROW_W-1:0] row_q;
    pair_t            second_q;
    logic             row_take, second_take;

    logic [IDX_W-1:0] full_idx, from_idx, to_idx;
    logic             full_any, from_any, to_any, part_ok;
    pair_t            full_pair, from_pair, to_pair;

    function automatic pair_t make_pair(input logic [ROW_W-1:0] row,
                                        input logic [X_W-1:0] lx,
                                        input logic [X_W-1:0] rx);
        pair_t        p;
        logic [X_W:0] sum;
        sum     = {1'b0, lx} + {1'b0, rx};
        p.row   = row;
        p.disp  = lx - rx;
        p.xmean = sum[X_W:1];
        return p;
    endfunction

    // Lowest-position winners for the full and the partial search.
    always_comb begin
        full_idx = '0;
        from_idx = '0;
        to_idx   = '0;
        to_any   = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (full_hit_i[i]) full_idx = IDX_W'(i);
            if (from_hit_i[i]) from_idx = IDX_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (to_hit_i[i] && IDX_W'(i) > from_idx) begin
                to_idx = IDX_W'(i);
                to_any = 1'b1;
            end
        end
    end

    assign full_any  = |full_hit_i;
    assign from_any  = |from_hit_i;
    assign part_ok   = from_any && to_any;
    assign full_pair = make_pair(row_q, cam_x_i[full_idx], rq_x_i);
    assign from_pair = make_pair(row_q, cam_x_i[from_idx], rq_x_i);
    assign to_pair   = make_pair(row_q, cam_x_i[to_idx], rq_x_i);

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Outputs and next state.
    always_comb begin
        state_d       = state_q;
        lq_pop_o      = 1'b0;
        rq_pop_o      = 1'b0;
        cam_flush_o   = 1'b0;
        cam_load_o    = 1'b0;
        cam_shift_o   = 1'b0;
        cam_shift_n_o = '0;
        res_push_o    = 1'b0;
        res_data_o    = full_pair;
        row_take      = 1'b0;
        second_take   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!rq_empty_i) begin
                    if (cam_count_i == '0 || rq_row_i != row_q) begin
                        cam_flush_o = 1'b1;
                        row_take    = 1'b1;
                        state_d     = ST_LOAD;
                    end else if (!lq_empty_i && lq_row_i == row_q && cam_count_i < CAP) begin
                        state_d = ST_LOAD;
                    end else begin
                        state_d = ST_MATCH;
                    end
                end
            end
            ST_LOAD: begin
                if (!lq_empty_i && lq_row_i < row_q) begin
                    lq_pop_o = 1'b1;
                end else if (!lq_empty_i && lq_row_i == row_q && cam_count_i < CAP) begin
                    lq_pop_o   = 1'b1;
                    cam_load_o = 1'b1;
                end else begin
                    state_d = ST_MATCH;
                end
            end
            ST_MATCH: begin
                if (full_any) begin
                    if (!res_full_i) begin
                        res_push_o    = 1'b1;
                        res_data_o    = full_pair;
                        cam_shift_o   = 1'b1;
                        cam_shift_n_o = CNT_W'(full_idx) + CNT_W'(1);
                        rq_pop_o      = 1'b1;
                        state_d       = ST_IDLE;
                    end
                end else if (part_ok) begin
                    if (!res_full_i) begin
                        res_push_o    = 1'b1;
                        res_data_o    = from_pair;
                        second_take   = 1'b1;
                        cam_shift_o   = 1'b1;
                        cam_shift_n_o = CNT_W'(to_idx) + CNT_W'(1);
                        rq_pop_o      = 1'b1;
                        state_d       = ST_SECOND;
                    end
                end else begin
                    rq_pop_o = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_SECOND: begin
                res_data_o = second_q;
                if (!res_full_i) begin
                    res_push_o = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            row_q    <= '0;
            second_q <= '0;
        end else begin
            if (row_take)    row_q    <= rq_row_i;
            if (second_take) second_q <= to_pair;
        end
    end

    assert_res_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_push_o |-> !res_full_i);
    assert_disp_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_push_o |-> (res_data_o.disp <= X_W'(MAX_DISP)));
    assert_result_row_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_push_o && state_q == ST_MATCH) |-> (res_data_o.row == rq_row_i));
    assert_second_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SECOND) |-> ($past(state_q) == ST_MATCH || $past(state_q) == ST_SECOND));
    assert_right_consume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rq_pop_o |-> (state_q == ST_MATCH && !rq_empty_i));
    assert_load_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cam_load_o |-> (lq_row_i == row_q));
endmodule

// File: rtl/stereo_matcher.sv
module stereo_matcher
    import stm_pkg::*;
#(
    parameter int CAM_ENTRIES = 8,
    parameter int FIFO_DEPTH  = 16,
    parameter int MAX_DISP    = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_valid,
    output logic             l_ready,
    input  logic [ROW_W-1:0] l_row,
    input  logic [X_W-1:0]   l_x,
    input  logic [COL_W-1:0] l_from,
    input  logic [COL_W-1:0] l_to,
    input  logic             r_valid,
    output logic             r_ready,
    input  logic [ROW_W-1:0] r_row,
    input  logic [X_W-1:0]   r_x,
    input  logic [COL_W-1:0] r_from,
    input  logic [COL_W-1:0] r_to,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [ROW_W-1:0] m_row,
    output logic [X_W-1:0]   m_disp,
    output logic [X_W-1:0]   m_xmean
);
    localparam int CNT_W = $clog2(CAM_ENTRIES + 1);
    localparam int TW    = $bits(trans_t);
    localparam int PW    = $bits(pair_t);

    trans_t l_in, r_in, lq_head, rq_head;
    pair_t  res_in, res_head;
    logic   lq_empty, lq_full, lq_pop, rq_empty, rq_full, rq_pop;
    logic   res_empty, res_full, res_push;

    logic                             cam_flush, cam_load, cam_shift;
    logic [CNT_W-1:0]                 cam_shift_n, cam_count;
    logic [CAM_ENTRIES-1:0][X_W-1:0]  cam_x;
    logic [CAM_ENTRIES-1:0]           full_hit, from_hit, to_hit;

    assign l_in    = '{row: l_row, body: '{x: l_x, c_from: l_from, c_to: l_to}};
    assign r_in    = '{row: r_row, body: '{x: r_x, c_from: r_from, c_to: r_to}};
    assign l_ready = !lq_full;
    assign r_ready = !rq_full;
    assign m_valid = !res_empty;
    assign m_row   = res_head.row;
    assign m_disp  = res_head.disp;
    assign m_xmean = res_head.xmean;

    stm_fifo #(.W(TW), .DEPTH(FIFO_DEPTH)) u_left_q (
        .clk_i(clk), .rst_ni(rst_n), .push_i(l_valid && l_ready), .data_i(l_in),
        .pop_i(lq_pop), .data_o(lq_head), .empty_o(lq_empty), .full_o(lq_full));

    stm_fifo #(.W(TW), .DEPTH(FIFO_DEPTH)) u_right_q (
        .clk_i(clk), .rst_ni(rst_n), .push_i(r_valid && r_ready), .data_i(r_in),
        .pop_i(rq_pop), .data_o(rq_head), .empty_o(rq_empty), .full_o(rq_full));

    stm_fifo #(.W(PW), .DEPTH(FIFO_DEPTH)) u_result_q (
        .clk_i(clk), .rst_ni(rst_n), .push_i(res_push), .data_i(res_in),
        .pop_i(m_valid && m_ready), .data_o(res_head), .empty_o(res_empty), .full_o(res_full));

    stm_cam #(.ENTRIES(CAM_ENTRIES), .MAX_DISP(MAX_DISP)) u_cam (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(cam_flush), .load_i(cam_load),
        .load_data_i(lq_head.body), .shift_i(cam_shift), .shift_n_i(cam_shift_n),
        .probe_from_i(rq_head.body.c_from), .probe_to_i(rq_head.body.c_to),
        .probe_x_i(rq_head.body.x), .count_o(cam_count), .x_o(cam_x),
        .full_hit_o(full_hit), .from_hit_o(from_hit), .to_hit_o(to_hit));

    stm_ctrl #(.ENTRIES(CAM_ENTRIES), .MAX_DISP(MAX_DISP)) u_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .lq_empty_i(lq_empty), .lq_row_i(lq_head.row), .lq_pop_o(lq_pop),
        .rq_empty_i(rq_empty), .rq_row_i(rq_head.row), .rq_x_i(rq_head.body.x), .rq_pop_o(rq_pop),
        .cam_count_i(cam_count), .cam_x_i(cam_x), .full_hit_i(full_hit),
        .from_hit_i(from_hit), .to_hit_i(to_hit), .cam_flush_o(cam_flush),
        .cam_load_o(cam_load), .cam_shift_o(cam_shift), .cam_shift_n_o(cam_shift_n),
        .res_full_i(res_full), .res_push_o(res_push), .res_data_o(res_in));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_row) && $stable(m_disp) && $stable(m_xmean)));
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!m_valid && l_ready && r_ready));
endmodule

// File: tb/stereo_matcher_bench.sv
module stereo_matcher_bench;
    import stm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int EW = ROW_W + 2 * X_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             l_valid = 1'b0, r_valid = 1'b0, m_ready = 1'b1;
    logic             l_ready, r_ready, m_valid;
    logic [ROW_W-1:0] l_row = '0, r_row = '0, m_row;
    logic [X_W-1:0]   l_x = '0, r_x = '0, m_disp, m_xmean;
    logic [COL_W-1:0] l_from = '0, l_to = '0, r_from = '0, r_to = '0;

    int      checks = 0;
    int      errors = 0;
    bit      done = 1'b0;
    bit      hold = 1'b0;
    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    stereo_matcher #(.CAM_ENTRIES(8), .FIFO_DEPTH(16), .MAX_DISP(150)) u_stereo_matcher (
        .clk(clk), .rst_n(rst_n),
        .l_valid(l_valid), .l_ready(l_ready), .l_row(l_row), .l_x(l_x), .l_from(l_from), .l_to(l_to),
        .r_valid(r_valid), .r_ready(r_ready), .r_row(r_row), .r_x(r_x), .r_from(r_from), .r_to(r_to),
        .m_valid(m_valid), .m_ready(m_ready), .m_row(m_row), .m_disp(m_disp), .m_xmean(m_xmean));

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic expect_pair(input string tag, input int row, input int lx, input int rx);
        exp_q.push_back({ROW_W'(row), X_W'(lx - rx), X_W'((lx + rx) / 2)});
        tag_q.push_back(tag);
    endtask

    task automatic send_l(input int row, input int x, input int f, input int t);
        logic acc;
        @(negedge clk);
        l_valid = 1'b1; l_row = ROW_W'(row); l_x = X_W'(x);
        l_from = COL_W'(f); l_to = COL_W'(t);
        do begin acc = l_ready; @(negedge clk); end while (!acc);
        l_valid = 1'b0;
    endtask

    task automatic send_r(input int row, input int x, input int f, input int t);
        logic acc;
        @(negedge clk);
        r_valid = 1'b1; r_row = ROW_W'(row); r_x = X_W'(x);
        r_from = COL_W'(f); r_to = COL_W'(t);
        do begin acc = r_ready; @(negedge clk); end while (!acc);
        r_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (30) @(negedge clk);
    endtask

    // Monitor: compares each accepted result with the head of the scoreboard.
    logic             stall_seen = 1'b0;
    logic [EW-1:0]    stall_val;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (stall_seen)
                check(m_valid && {m_row, m_disp, m_xmean} == stall_val,
                      "R9 result held while stalled", int'(m_disp), int'(stall_val[X_W*2-1:X_W]));
            m_ready = !hold;
            stall_seen = 1'b0;
            if (m_valid && !m_ready) begin
                stall_seen = 1'b1;
                stall_val  = {m_row, m_disp, m_xmean};
            end
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result (row)", int'(m_row), -1);
                end else begin
                    logic [EW-1:0] e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(m_row == e[EW-1:2*X_W], {tg, " row"}, int'(m_row), int'(e[EW-1:2*X_W]));
                    check(m_disp == e[2*X_W-1:X_W], {tg, " disparity"}, int'(m_disp), int'(e[2*X_W-1:X_W]));
                    check(m_xmean == e[X_W-1:0], {tg, " mean x"}, int'(m_xmean), int'(e[X_W-1:0]));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(l_ready == 1'b1, "R1 l_ready in reset", int'(l_ready), 1);
        check(r_ready == 1'b1, "R1 r_ready in reset", int'(r_ready), 1);
        check(m_valid == 1'b0, "R1 m_valid in reset", int'(m_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);

        // R2: plain matches, odd sum rounds down.
        send_l(1, 300, 2, 7);
        send_l(1, 301, 4, 5);
        expect_pair("R2 basic", 1, 300, 280);
        send_r(1, 280, 2, 7);
        expect_pair("R2 odd mean", 1, 301, 280);
        send_r(1, 280, 4, 5);
        drain();

        // R4: matched entry and the ones before it leave the store.
        send_l(10, 100, 1, 2);
        send_l(10, 120, 3, 4);
        send_l(10, 140, 1, 2);
        expect_pair("R4 middle entry", 10, 120, 95);
        send_r(10, 95, 3, 4);
        expect_pair("R4 earlier entry gone", 10, 140, 90);
        send_r(10, 90, 1, 2);
        drain();

        // R3: over-limit and negative candidates skipped; exact limit accepted.
        send_l(20, 400, 5, 6);
        send_l(20, 260, 5, 6);
        expect_pair("R3 over limit skipped", 20, 260, 240);
        send_r(20, 240, 5, 6);
        send_l(21, 50, 5, 6);
        send_l(21, 130, 5, 6);
        expect_pair("R3 negative skipped", 21, 130, 100);
        send_r(21, 100, 5, 6);
        send_l(22, 250, 5, 6);
        expect_pair("R3 limit accepted", 22, 250, 100);
        send_r(22, 100, 5, 6);
        drain();

        // R6: partial match gives two results, from-colour entry first.
        send_l(30, 200, 1, 8);
        send_l(30, 230, 8, 3);
        expect_pair("R6 first of partial", 30, 200, 190);
        expect_pair("R6 second of partial", 30, 230, 190);
        send_r(30, 190, 1, 3);
        drain();

        // R7: to-colour only before from-colour: discarded, store kept.
        send_l(31, 200, 8, 3);
        send_l(31, 220, 1, 8);
        send_r(31, 190, 1, 3);
        expect_pair("R7 store intact after discard", 31, 220, 210);
        send_r(31, 210, 1, 8);
        drain();

        // R5: ten left records; only eight fit, the rest enter after a match.
        for (int k = 0; k < 10; k++) send_l(40, 100 + 10 * k, k, k + 1);
        send_r(40, 175, 8, 9);
        expect_pair("R5 eighth entry", 40, 170, 165);
        send_r(40, 165, 7, 8);
        expect_pair("R5 top-up entry", 40, 190, 180);
        send_r(40, 180, 9, 10);
        drain();

        // R8: stale left row dropped, row change reloads, no-left right discarded.
        send_l(50, 300, 2, 3);
        send_l(51, 310, 2, 3);
        expect_pair("R8 stale dropped", 51, 310, 300);
        send_r(51, 300, 2, 3);
        send_r(52, 100, 2, 3);
        drain();
        send_l(52, 120, 2, 3);
        expect_pair("R8 row reload", 52, 120, 100);
        send_r(52, 100, 2, 3);
        drain();

        // R10: result queue fills while m_ready is low; everything drains in order.
        hold = 1'b1;
        for (int i = 0; i < 20; i++) begin
            send_l(100 + i, 200 + i, 6, 9);
            expect_pair("R10 backpressure", 100 + i, 200 + i, 190);
            send_r(100 + i, 190, 6, 9);
        end
        repeat (60) @(negedge clk);
        check(m_valid == 1'b1, "R10 valid while stalled", int'(m_valid), 1);
        check(exp_q.size() == 20, "R10 nothing consumed while stalled", exp_q.size(), 20);
        hold = 1'b0;
        drain();

        check(exp_q.size() == 0, "R10 missing results", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule